// File: doc/BRIEF.md
# SD Data Timeout Timer

This block watches the data phase of an SD card transfer and flags a data timeout when the card stays silent too long. It counts cycles of the card clock, but only those in which the card clock is actually running. When the count reaches a programmable limit, it sets a sticky status bit. The limit is a power of two: 2^(code+13) card clocks, where the 4-bit code comes from a control word written by software. The code field sits at bits 19:16 of that word.

The data path asserts a start pulse at the beginning of every block. Each pulse zeroes the count and arms the timer. A transfer-complete pulse freezes the timer so that it cannot expire. On expiry the timer disarms itself. The status bit stays set until software clears it with a write-one pulse.

Beside the timer, a combinational helper suggests a code for a given card clock frequency. The suggested code is the number of significant bits of (frequency / 4), minus 13, limited to 0..14. This yields at least a quarter second of timeout. When the avoidance option is enabled, suggested codes 4, 8 and 12 are raised by one.

Top module: `sd_data_timeout`

## Requirements
- R1: After reset the programmed code reads 14, the timeout flag is 0 and the timer is disarmed, so it does not expire until the next start pulse.
- R2: A control write takes the code from bits 19:16 of the written word and ignores all other bits. The value 15 is stored as 14.
- R3: A start pulse zeroes the count and arms the timer, even if the timer is already armed. Each new block therefore gets a full period.
- R4: With the timer armed and the card clock always enabled, the timeout flag reads 1 right after the 2^(code+13)-th clock edge that follows the arming edge. It reads 0 after the edge before that one.
- R5: Edges where the card clock enable is 0 are not counted, however many of them occur.
- R6: A transfer-complete pulse disarms the timer, so no timeout follows. This also holds when the pulse falls on the edge that would otherwise have expired.
- R7: The timeout flag stays set until a clear pulse. If expiry and clear fall on the same edge, the flag ends up set. After expiry the timer stays disarmed, so clearing the flag does not lead to a second timeout without a new start pulse.
- R8: The suggested code equals (number of significant bits of frequency/4) − 13, forced into 0..14. Examples: 200 kHz gives 3, 25 MHz gives 10, 52 MHz gives 11, 200 MHz gives 13, 400 MHz and above give 14, and 0 gives 0.
- R9: With the avoidance option on (the default), a suggested code of 4, 8 or 12 is output as 5, 9 or 13.
- R10: A start pulse and a transfer-complete pulse on the same edge leave the timer armed with a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word; code in bits 19:16 |
| sts_clr_i | input | 1 | Write-one pulse that clears the timeout flag |
| card_clk_en_i | input | 1 | Card clock running in this cycle |
| phase_start_i | input | 1 | Start of a block's data phase |
| xfer_done_i | input | 1 | Transfer complete |
| card_freq_hz_i | input | 32 | Card clock frequency in Hz |
| code_o | output | 4 | Programmed timeout code |
| rec_code_o | output | 4 | Suggested timeout code |
| timeout_o | output | 1 | Sticky data-timeout flag |

## Verification
Three pairs of events can fall on the same edge, and the bench puts each pair on one edge on purpose. It counts exactly 2^13 − 1 enabled edges after arming, then raises the second event on the final counting edge:

- Expiry with a status clear: the flag must end up set.
- Expiry with transfer-complete: no timeout may appear.
- A start pulse with transfer-complete: the timer must stay armed.

A behavioural reference model judges every edge. Directed checks also read the flag one edge before and exactly at the limit.

// File: rtl/sdto_pkg.sv
package sdto_pkg;
  localparam int unsigned SDTO_CODE_W   = 4;
  localparam int unsigned SDTO_CODE_LSB = 16;
  localparam int unsigned SDTO_BASE_EXP = 13;
  localparam int unsigned SDTO_MAX_CODE = 14;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_st_t;
endpackage

// File: rtl/sdto_code_reg.sv
module sdto_code_reg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned CODE_LSB = 16,
  parameter int unsigned MAX_CODE = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned FIELD_HI = CODE_LSB + CODE_W - 1;

  logic [CODE_W-1:0] code_q, code_d, field;
  logic              unused_bits;

  assign field       = wr_data_i[FIELD_HI:CODE_LSB];
  assign unused_bits = ^{wr_data_i[DATA_W-1:FIELD_HI+1], wr_data_i[CODE_LSB-1:0]};

  // Saturate requests above the legal maximum.
  always_comb begin
    if (int'(field) > int'(MAX_CODE)) code_d = CODE_W'(MAX_CODE);
    else                              code_d = field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= CODE_W'(MAX_CODE);
    else if (wr_en_i) code_q <= code_d;
  end

  assign code_o = code_q;

  AST_CODE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(code_q) <= int'(MAX_CODE)); // R2
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(code_q)); // R2
endmodule

// File: rtl/sdto_rec_code.sv
module sdto_rec_code #(
  parameter int unsigned FREQ_W   = 32,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned BASE_EXP = 13,
  parameter int unsigned MAX_CODE = 14,
  parameter bit          AVOID    = 1'b1
) (
  input  logic [FREQ_W-1:0] freq_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned SCAN_W = FREQ_W - 2;
  localparam int unsigned NB_W   = $clog2(SCAN_W + 1);

  logic [NB_W-1:0]   nbits;
  logic [CODE_W-1:0] raw;
  logic              unused_lsbs;
  int                diff;

  assign unused_lsbs = ^freq_i[1:0];

  // Count significant bits of freq/4 (highest set bit, one-based).
  always_comb begin
    nbits = '0;
    for (int i = 0; i < int'(SCAN_W); i++) begin
      if (freq_i[i+2]) nbits = NB_W'(i + 1);
    end
  end

  always_comb begin
    diff = int'(nbits) - int'(BASE_EXP);
    if (diff < 0)                    raw = '0;
    else if (diff > int'(MAX_CODE))  raw = CODE_W'(MAX_CODE);
    else                             raw = CODE_W'(diff);
  end

  generate
    if (AVOID) begin : g_avoid
      always_comb begin
        if (raw == CODE_W'(4) || raw == CODE_W'(8) || raw == CODE_W'(12))
          code_o = raw + CODE_W'(1);
        else
          code_o = raw;
      end
    end else begin : g_plain
      assign code_o = raw;
    end
  endgenerate
endmodule

// File: rtl/sdto_counter.sv
module sdto_counter
  import sdto_pkg::*;
#(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned BASE_EXP = 13,
  parameter int unsigned MAX_CODE = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              cen_i,
  input  logic              phase_start_i,
  input  logic              xfer_done_i,
  input  logic              sts_clr_i,
  output logic              timeout_o
);
  localparam int unsigned CNT_W = BASE_EXP + MAX_CODE + 1;

  run_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt;
  logic             cnt_ld, at_limit, expire;
  logic             to_q, to_d;

  assign last_cnt = ({{(CNT_W-1){1'b0}}, 1'b1} << (32'(code_i) + BASE_EXP)) - CNT_W'(1);
  assign at_limit = (cnt_q >= last_cnt);

  // Next state: start beats done, done beats expiry.
  always_comb begin
    expire = (st_q == ST_RUN) && cen_i && !phase_start_i && !xfer_done_i && at_limit;
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_ld = 1'b0;
    if (phase_start_i) begin
      st_d   = ST_RUN;
      cnt_d  = '0;
      cnt_ld = 1'b1;
    end else if (xfer_done_i || expire) begin
      st_d   = ST_IDLE;
    end else if (st_q == ST_RUN && cen_i) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_ld = 1'b1;
    end
    to_d = expire || (to_q && !sts_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      to_q <= 1'b0;
    end else begin
      st_q <= st_d;
      to_q <= to_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign timeout_o = to_q;

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    phase_start_i |=> (cnt_q == '0) && (st_q == ST_RUN)); // R3
  AST_GATED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !cen_i && !phase_start_i |=> $stable(cnt_q)); // R5
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && !phase_start_i |=> $stable(cnt_q) && !$rose(to_q)); // R6
  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i && !phase_start_i |=> (st_q == ST_IDLE)); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    to_q && !sts_clr_i |=> to_q); // R7
  AST_EXPIRY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> (st_q == ST_IDLE)); // R7
endmodule

// File: rtl/sd_data_timeout.sv
module sd_data_timeout
  import sdto_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FREQ_W   = 32,
  parameter int unsigned CODE_W   = SDTO_CODE_W,
  parameter int unsigned CODE_LSB = SDTO_CODE_LSB,
  parameter int unsigned BASE_EXP = SDTO_BASE_EXP,
  parameter int unsigned MAX_CODE = SDTO_MAX_CODE,
  parameter bit          AVOID    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] ctrl_wdata_i,
  input  logic              sts_clr_i,
  input  logic              card_clk_en_i,
  input  logic              phase_start_i,
  input  logic              xfer_done_i,
  input  logic [FREQ_W-1:0] card_freq_hz_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] rec_code_o,
  output logic              timeout_o
);
  logic [CODE_W-1:0] code;

  sdto_code_reg #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB), .MAX_CODE(MAX_CODE)
  ) u_code (
    .clk(clk), .rst_n(rst_n), .wr_en_i(ctrl_we_i), .wr_data_i(ctrl_wdata_i),
    .code_o(code)
  );

  sdto_counter #(
    .CODE_W(CODE_W), .BASE_EXP(BASE_EXP), .MAX_CODE(MAX_CODE)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .code_i(code), .cen_i(card_clk_en_i),
    .phase_start_i(phase_start_i), .xfer_done_i(xfer_done_i),
    .sts_clr_i(sts_clr_i), .timeout_o(timeout_o)
  );

  sdto_rec_code #(
    .FREQ_W(FREQ_W), .CODE_W(CODE_W), .BASE_EXP(BASE_EXP),
    .MAX_CODE(MAX_CODE), .AVOID(AVOID)
  ) u_rec (
    .freq_i(card_freq_hz_i), .code_o(rec_code_o)
  );

  assign code_o = code;

  AST_REC_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rec_code_o) <= int'(MAX_CODE)); // R8
  generate
    if (AVOID) begin : g_chk_avoid
      AST_REC_AVOID: assert property (@(posedge clk) disable iff (!rst_n)
        rec_code_o != CODE_W'(4) && rec_code_o != CODE_W'(8) && rec_code_o != CODE_W'(12)); // R9
    end
  endgenerate
endmodule

// File: tb/sd_data_timeout_test.sv
module sd_data_timeout_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        sts_clr = 1'b0;
  logic        cen = 1'b0;
  logic        ps = 1'b0;
  logic        xd = 1'b0;
  logic [31:0] freq = '0;
  logic [3:0]  code_o, rec_code_o;
  logic        timeout_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  longint m_cnt;
  bit     m_arm, m_to;
  int     m_code;

  sd_data_timeout uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .sts_clr_i(sts_clr), .card_clk_en_i(cen), .phase_start_i(ps),
    .xfer_done_i(xd), .card_freq_hz_i(freq), .code_o(code_o),
    .rec_code_o(rec_code_o), .timeout_o(timeout_o)
  );

  always #10 clk = ~clk;

  function automatic int rec_ref(input logic [31:0] f);
    logic [31:0] x;
    int n, c;
    x = f >> 2;
    n = 0;
    while (x != 0) begin
      n++;
      x = x >> 1;
    end
    c = n - 13;
    if (c < 0) c = 0;
    if (c > 14) c = 14;
    if (c == 4 || c == 8 || c == 12) c++;
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_arm = 0; m_to = 0; m_code = 14;
    end else begin
      longint lim;
      bit ex;
      lim = longint'(1) << (m_code + 13);
      ex = m_arm && cen && !ps && !xd && (m_cnt + 1 >= lim);
      if (ps) begin
        m_arm = 1; m_cnt = 0;
      end else if (xd || ex) begin
        m_arm = 0;
      end else if (m_arm && cen) begin
        m_cnt = m_cnt + 1;
      end
      m_to = ex || (m_to && !sts_clr);
      if (ctrl_we) begin
        m_code = int'((ctrl_wdata >> 16) & 32'hF);
        if (m_code > 14) m_code = 14;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk(timeout_o == m_to, "R4/R7 model timeout", timeout_o, m_to);
      chk(int'(code_o) == m_code, "R2 model code", code_o, m_code);
      chk(int'(rec_code_o) == rec_ref(freq), "R8 model rec", rec_code_o, rec_ref(freq));
    end
    if (cycles >= 195000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic arm();
    sts_clr = 1; ps = 1; tick(); ps = 0; sts_clr = 0;
  endtask

  task automatic rec_chk(input logic [31:0] f, input int exp, input string req);
    freq = f; tick();
    chk(int'(rec_code_o) == exp, req, rec_code_o, exp);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk(code_o == 4'd14, "R1 reset code", code_o, 14);
    chk(timeout_o == 1'b0, "R1 reset flag", timeout_o, 0);
    cen = 1;
    repeat (50) tick();
    chk(timeout_o == 1'b0, "R1 disarmed", timeout_o, 0);

    // R8 / R9 suggested code
    rec_chk(32'd0, 0, "R8 zero freq");
    rec_chk(32'd200000, 3, "R8 200k");
    rec_chk(32'd400000, 5, "R9 400k bump 4");
    rec_chk(32'd6000000, 9, "R9 6M bump 8");
    rec_chk(32'd25000000, 10, "R8 25M");
    rec_chk(32'd52000000, 11, "R8 52M");
    rec_chk(32'd100000000, 13, "R9 100M bump 12");
    rec_chk(32'd200000000, 13, "R8 200M");
    rec_chk(32'd400000000, 14, "R8 clamp 400M");
    rec_chk(32'hFFFF_FFFF, 14, "R8 clamp max");

    // R2 code field
    ctrl_we = 1; ctrl_wdata = 32'h000F_0000; tick(); ctrl_we = 0;
    chk(code_o == 4'd14, "R2 saturate 15", code_o, 14);
    ctrl_we = 1; ctrl_wdata = 32'hA5A7_5A5A; tick(); ctrl_we = 0;
    chk(code_o == 4'd7, "R2 field bits", code_o, 7);
    ctrl_we = 1; ctrl_wdata = 32'hFFF0_FFFF; tick(); ctrl_we = 0;
    chk(code_o == 4'd0, "R2 code 0", code_o, 0);

    // R4 exact limit
    arm(); cen = 1;
    repeat (8191) tick();
    chk(timeout_o == 1'b0, "R4 before limit", timeout_o, 0);
    tick();
    chk(timeout_o == 1'b1, "R4 at limit", timeout_o, 1);

    // R7 clear, no second expiry
    sts_clr = 1; tick(); sts_clr = 0;
    chk(timeout_o == 1'b0, "R7 cleared", timeout_o, 0);
    repeat (9000) tick();
    chk(timeout_o == 1'b0, "R7 stays disarmed", timeout_o, 0);

    // R5 gating
    arm(); cen = 0;
    repeat (20000) tick();
    chk(timeout_o == 1'b0, "R5 gated hold", timeout_o, 0);
    cen = 1;
    repeat (8191) tick();
    chk(timeout_o == 1'b0, "R5 gated before", timeout_o, 0);
    tick();
    chk(timeout_o == 1'b1, "R5 gated at limit", timeout_o, 1);
    arm();
    for (int i = 0; i < 16382; i++) begin
      cen = i[0]; tick();
    end
    chk(timeout_o == 1'b0, "R5 alternating before", timeout_o, 0);
    cen = 1; tick();
    chk(timeout_o == 1'b1, "R5 alternating at limit", timeout_o, 1);

    // R3 restart per block
    arm(); cen = 1;
    repeat (8000) tick();
    ps = 1; tick(); ps = 0;
    repeat (8191) tick();
    chk(timeout_o == 1'b0, "R3 restart before", timeout_o, 0);
    tick();
    chk(timeout_o == 1'b1, "R3 restart at limit", timeout_o, 1);

    // R6 freeze
    arm(); cen = 1;
    repeat (5000) tick();
    xd = 1; tick(); xd = 0;
    repeat (10000) tick();
    chk(timeout_o == 1'b0, "R6 frozen", timeout_o, 0);
    arm();
    repeat (8191) tick();
    xd = 1; tick(); xd = 0;
    chk(timeout_o == 1'b0, "R6 done on expiry edge", timeout_o, 0);
    repeat (100) tick();
    chk(timeout_o == 1'b0, "R6 still clear", timeout_o, 0);

    // R7 expiry and clear together
    arm();
    repeat (8191) tick();
    sts_clr = 1; tick(); sts_clr = 0;
    chk(timeout_o == 1'b1, "R7 set beats clear", timeout_o, 1);

    // R10 start and done together
    sts_clr = 1; ps = 1; xd = 1; tick(); ps = 0; xd = 0; sts_clr = 0;
    repeat (8191) tick();
    chk(timeout_o == 1'b0, "R10 before limit", timeout_o, 0);
    tick();
    chk(timeout_o == 1'b1, "R10 armed", timeout_o, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule